// File: doc/BRIEF.md
# Interrupt and Single-Step Trace Sequencer

This block decides where a small 32-bit CPU goes after each retired instruction. The core hands it a retire strobe, the address that would normally follow, a register operand and decoded requests for five special operations: write the control word, write the interrupt vector, return from interrupt, return from trace, and read the trace return address. From these inputs and its own state it picks one next program counter. The choices are the sequential address, the interrupt vector, the fixed trace handler at 0x00000002, or one of two saved return addresses.

There are two event sources and no stack. Each source has one dedicated return register. Trace events win over the external interrupt, so interrupt handler code can itself be single-stepped. A bus-wait input freezes every decision and every register update.

Top module: `irq_trace_seq`

## Requirements
- R1: After reset the control word, the vector and both return registers are zero and no handler is active. With no control-word write, no retire ever takes an event, next_pc_o equals seq_pc_i, and a trace-return read returns 0.
- R2: An interrupt is accepted on an accepted retire (retire_i=1, wait_i=0) when irq_i=1, control bit 0 is set, no interrupt handler is active, and no trace handler is active (a retiring return-from-trace is the exception). On acceptance take_irq_o=1, next_pc_o equals the vector, and the retire's normal target is saved as the interrupt return address.
- R3: A set-vector request (op_setiv_i) on an accepted retire loads data_i into the vector. The new value is used from the next retire on.
- R4: A return-from-interrupt request (op_reti_i) on an accepted retire makes the retire's target equal the saved interrupt return address and ends the interrupt handler.
- R5: While the interrupt handler is active, a high irq_i is masked. This includes the retire that carries the return-from-interrupt. It is honoured again on the following retire.
- R6: With control bit 31 set, an accepted retire outside the trace handler takes a trace event. take_trace_o=1, next_pc_o=0x00000002, and the retire's normal target is saved as the trace return address.
- R7: Instructions retired inside the trace handler are not traced. A return-from-trace request (op_rett_i) redirects to the trace return address and ends the handler, and the next retired instruction is traced again.
- R8: When both a trace event and an interrupt qualify on one retire, only the trace event is taken. An interrupt may be taken on the return-from-trace retire, and the first handler instruction that follows is then traced.
- R9: rd_data_o equals the trace return address while op_gettr_i=1 and is 0 otherwise.
- R10: A control-word write (op_setcw_i) takes data_i bit 0 as the interrupt enable and bit 31 as the trace enable, from the next retire on. Bits 30..1 have no effect. Clearing bit 31 stops further trace events.
- R11: With wait_i=1 no event is taken, next_pc_o equals seq_pc_i, and no register changes, including writes and returns requested in that cycle.
- R12: With retire_i=0 no event is taken and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_i | input | 1 | Bus wait, freezes the block |
| retire_i | input | 1 | An instruction retires this cycle |
| seq_pc_i | input | 32 | Normal next address of the retiring instruction |
| irq_i | input | 1 | External interrupt level, active high |
| data_i | input | 32 | Register operand for control-word and vector writes |
| op_setcw_i | input | 1 | Write control word |
| op_setiv_i | input | 1 | Write interrupt vector |
| op_reti_i | input | 1 | Return from interrupt |
| op_rett_i | input | 1 | Return from trace |
| op_gettr_i | input | 1 | Read trace return address |
| next_pc_o | output | 32 | Next program counter |
| take_irq_o | output | 1 | Interrupt taken on this retire |
| take_trace_o | output | 1 | Trace event taken on this retire |
| rd_data_o | output | 32 | Trace return address read data |

## Verification
Every piece of internal state shows on next_pc_o or the take strobes no later than the next accepted retire that depends on it. A wrong enable bit shows up as an event that is taken or missed. A wrong vector or return register shows up as a wrong redirect target. A stuck handler flag shows up as a missing re-entry or a missing trace after a return. The trace return register is also visible at once through rd_data_o, so a bad save is caught within the same handler visit that follows it.

// File: rtl/irq_trace_pkg.sv
package irq_trace_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [2:0] {
    SRC_SEQ,
    SRC_IRQ_VEC,
    SRC_TRC_VEC,
    SRC_IRQ_RTN,
    SRC_TRC_RTN
  } pc_src_e;
endpackage

// File: rtl/its_ctrl_regs.sv
module its_ctrl_regs #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IRQ_EN_BIT = 0,
  parameter int unsigned TRC_EN_BIT = 31
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_cw_i,
  input  logic            we_iv_i,
  input  logic [XLEN-1:0] data_i,
  output logic            irq_en_o,
  output logic            trc_en_o,
  output logic [XLEN-1:0] vec_o
);
  // reserved control bits are not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_o <= 1'b0;
      trc_en_o <= 1'b0;
    end else if (we_cw_i) begin
      irq_en_o <= data_i[IRQ_EN_BIT];
      trc_en_o <= data_i[TRC_EN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vec_o <= '0;
    else if (we_iv_i) vec_o <= data_i;
  end
endmodule

// File: rtl/its_arbiter.sv
module its_arbiter
  import irq_trace_pkg::*;
(
  input  logic    accept_i,
  input  logic    irq_i,
  input  logic    irq_en_i,
  input  logic    trc_en_i,
  input  logic    in_irq_i,
  input  logic    in_trc_i,
  input  logic    reti_i,
  input  logic    rett_i,
  output logic    take_irq_o,
  output logic    take_trc_o,
  output pc_src_e sel_o
);
  logic trc_ok, irq_ok;

  always_comb begin
    trc_ok = accept_i && trc_en_i && !in_trc_i;
    // irq may leave the trace handler only on its return
    irq_ok = accept_i && irq_en_i && irq_i && !in_irq_i && (!in_trc_i || rett_i);
    take_trc_o = trc_ok;
    take_irq_o = irq_ok && !trc_ok;
    if (take_trc_o)                 sel_o = SRC_TRC_VEC;
    else if (take_irq_o)            sel_o = SRC_IRQ_VEC;
    else if (accept_i && reti_i)    sel_o = SRC_IRQ_RTN;
    else if (accept_i && rett_i)    sel_o = SRC_TRC_RTN;
    else                            sel_o = SRC_SEQ;
  end
endmodule

// File: rtl/its_return_regs.sv
module its_return_regs #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            take_irq_i,
  input  logic            take_trc_i,
  input  logic            reti_i,
  input  logic            rett_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] irq_rtn_o,
  output logic [XLEN-1:0] trc_rtn_o,
  output logic            in_irq_o,
  output logic            in_trc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_rtn_o <= '0;
      in_irq_o  <= 1'b0;
    end else if (accept_i) begin
      if (take_irq_i) begin
        irq_rtn_o <= target_i;
        in_irq_o  <= 1'b1;
      end else if (reti_i) begin
        in_irq_o  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trc_rtn_o <= '0;
      in_trc_o  <= 1'b0;
    end else if (accept_i) begin
      if (take_trc_i) begin
        trc_rtn_o <= target_i;
        in_trc_o  <= 1'b1;
      end else if (rett_i) begin
        in_trc_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_trace_seq.sv
module irq_trace_seq
  import irq_trace_pkg::*;
#(
  parameter int unsigned            ADDR_W     = XLEN,
  parameter logic [ADDR_W-1:0]      TRC_VECTOR = 'h2,
  parameter int unsigned            IRQ_EN_BIT = 0,
  parameter int unsigned            TRC_EN_BIT = ADDR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_i,
  input  logic              retire_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic              irq_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic              op_setcw_i,
  input  logic              op_setiv_i,
  input  logic              op_reti_i,
  input  logic              op_rett_i,
  input  logic              op_gettr_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              take_irq_o,
  output logic              take_trace_o,
  output logic [ADDR_W-1:0] rd_data_o
);
  logic              accept;
  logic              irq_en_q, trc_en_q, in_irq_q, in_trc_q;
  logic [ADDR_W-1:0] vec_q, irq_rtn_q, trc_rtn_q, target;
  pc_src_e           sel;

  assign accept = retire_i && !wait_i;

  its_ctrl_regs #(
    .XLEN(ADDR_W), .IRQ_EN_BIT(IRQ_EN_BIT), .TRC_EN_BIT(TRC_EN_BIT)
  ) i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_cw_i  (accept && op_setcw_i),
    .we_iv_i  (accept && op_setiv_i),
    .data_i   (data_i),
    .irq_en_o (irq_en_q),
    .trc_en_o (trc_en_q),
    .vec_o    (vec_q)
  );

  its_arbiter i_arb (
    .accept_i   (accept),
    .irq_i      (irq_i),
    .irq_en_i   (irq_en_q),
    .trc_en_i   (trc_en_q),
    .in_irq_i   (in_irq_q),
    .in_trc_i   (in_trc_q),
    .reti_i     (op_reti_i),
    .rett_i     (op_rett_i),
    .take_irq_o (take_irq_o),
    .take_trc_o (take_trace_o),
    .sel_o      (sel)
  );

  // normal target of the retiring instruction, before any event
  always_comb begin
    if (op_reti_i)      target = irq_rtn_q;
    else if (op_rett_i) target = trc_rtn_q;
    else                target = seq_pc_i;
  end

  its_return_regs #(.XLEN(ADDR_W)) i_rtn (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .take_irq_i (take_irq_o),
    .take_trc_i (take_trace_o),
    .reti_i     (op_reti_i),
    .rett_i     (op_rett_i),
    .target_i   (target),
    .irq_rtn_o  (irq_rtn_q),
    .trc_rtn_o  (trc_rtn_q),
    .in_irq_o   (in_irq_q),
    .in_trc_o   (in_trc_q)
  );

  always_comb begin
    unique case (sel)
      SRC_IRQ_VEC: next_pc_o = vec_q;
      SRC_TRC_VEC: next_pc_o = TRC_VECTOR;
      SRC_IRQ_RTN: next_pc_o = irq_rtn_q;
      SRC_TRC_RTN: next_pc_o = trc_rtn_q;
      default:     next_pc_o = seq_pc_i;
    endcase
  end

  assign rd_data_o = op_gettr_i ? trc_rtn_q : '0;
endmodule

// File: rtl/irq_trace_seq_chk.sv
module irq_trace_seq_chk #(
  parameter int unsigned       ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] TRC_VECTOR = 'h2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wait_i,
  input logic              retire_i,
  input logic [ADDR_W-1:0] seq_pc_i,
  input logic              op_reti_i,
  input logic              op_rett_i,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic              take_irq_o,
  input logic              take_trace_o,
  input logic [ADDR_W-1:0] vec_q,
  input logic [ADDR_W-1:0] irq_rtn_q,
  input logic [ADDR_W-1:0] trc_rtn_q,
  input logic              in_irq_q,
  input logic              in_trc_q
);
  AST_IRQ_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_irq_o && !op_reti_i && !op_rett_i) |=> (irq_rtn_q == $past(seq_pc_i)))
    else $error("irq return not saved"); // R2

  AST_IRQ_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (next_pc_o == vec_q)) else $error("irq target"); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_irq_q |-> !take_irq_o) else $error("irq re-entry"); // R5

  AST_TRACE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_trace_o |-> (next_pc_o == TRC_VECTOR)) else $error("trace target"); // R6

  AST_TRACE_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_trace_o && !op_reti_i && !op_rett_i) |=> (trc_rtn_q == $past(seq_pc_i)))
    else $error("trace return not saved"); // R6

  AST_NO_NESTED_TRACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_trc_q |-> !take_trace_o) else $error("trace inside handler"); // R7

  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({take_irq_o, take_trace_o})) else $error("two events"); // R8

  AST_WAIT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_i |=> ($stable(vec_q) && $stable(irq_rtn_q) && $stable(trc_rtn_q)
                && $stable(in_irq_q) && $stable(in_trc_q)))
    else $error("state moved under wait"); // R11

  AST_IDLE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retire_i |=> ($stable(vec_q) && $stable(irq_rtn_q) && $stable(trc_rtn_q)))
    else $error("state moved without retire"); // R12
endmodule

bind irq_trace_seq irq_trace_seq_chk #(.ADDR_W(ADDR_W), .TRC_VECTOR(TRC_VECTOR)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wait_i       (wait_i),
  .retire_i     (retire_i),
  .seq_pc_i     (seq_pc_i),
  .op_reti_i    (op_reti_i),
  .op_rett_i    (op_rett_i),
  .next_pc_o    (next_pc_o),
  .take_irq_o   (take_irq_o),
  .take_trace_o (take_trace_o),
  .vec_q        (vec_q),
  .irq_rtn_q    (irq_rtn_q),
  .trc_rtn_q    (trc_rtn_q),
  .in_irq_q     (in_irq_q),
  .in_trc_q     (in_trc_q)
);

// File: tb/test_irq_trace_seq.sv
module test_irq_trace_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wait_s, retire, irq;
  logic [31:0] seq_pc, data;
  logic        setcw, setiv, reti, rett, gettr;
  logic [31:0] next_pc, rd_data;
  logic        take_irq, take_trace;
  int          n_vec = 0;
  int          n_err = 0;
  bit          done  = 0;

  localparam logic [4:0] OP_NONE = 5'b00000, OP_CW = 5'b10000, OP_IV = 5'b01000,
                         OP_RI = 5'b00100, OP_RT = 5'b00010, OP_GT = 5'b00001;

  always #5 clk = ~clk;

  irq_trace_seq i_irq_trace_seq (
    .clk_i(clk), .rst_ni(rst_n), .wait_i(wait_s), .retire_i(retire),
    .seq_pc_i(seq_pc), .irq_i(irq), .data_i(data),
    .op_setcw_i(setcw), .op_setiv_i(setiv), .op_reti_i(reti),
    .op_rett_i(rett), .op_gettr_i(gettr),
    .next_pc_o(next_pc), .take_irq_o(take_irq), .take_trace_o(take_trace),
    .rd_data_o(rd_data)
  );

  task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at negedge, check combinational outputs before the edge
  task automatic step(input logic [31:0] pc, input logic [4:0] ops, input logic [31:0] d,
                      input logic irq_v, input logic w, input logic ret,
                      input logic [31:0] exp_pc, input logic exp_i, input logic exp_t,
                      input string tag);
    @(negedge clk);
    seq_pc = pc; data = d; irq = irq_v; wait_s = w; retire = ret;
    {setcw, setiv, reti, rett, gettr} = ops;
    #1;
    chk32(next_pc, exp_pc, {tag, " next_pc"});
    chk32({31'd0, take_irq}, {31'd0, exp_i}, {tag, " take_irq"});
    chk32({31'd0, take_trace}, {31'd0, exp_t}, {tag, " take_trace"});
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wait_s = 0; retire = 0; irq = 0; seq_pc = 0; data = 0;
    {setcw, setiv, reti, rett, gettr} = OP_NONE;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    step(32'h8, OP_GT, 0, 1, 0, 1, 32'h8, 0, 0, "R1 idle after reset");
    chk32(rd_data, 32'h0, "R1 trace return cleared");
    step(32'h9, OP_NONE, 0, 1, 0, 1, 32'h9, 0, 0, "R1 no events");
    chk32(rd_data, 32'h0, "R9 zero without read");
  endtask

  task automatic t_irq();
    do_reset();
    step(32'h10, OP_IV, 32'h100, 0, 0, 1, 32'h10, 0, 0, "R3 set vector");
    step(32'h11, OP_CW, 32'h1, 1, 0, 1, 32'h11, 0, 0, "R10 cw not yet active");
    step(32'h20, OP_NONE, 0, 1, 0, 1, 32'h100, 1, 0, "R2 irq taken");
    step(32'h101, OP_NONE, 0, 1, 0, 1, 32'h101, 0, 0, "R5 irq masked in handler");
    step(32'h102, OP_RI, 0, 1, 0, 1, 32'h20, 0, 0, "R4 return from irq");
    step(32'h21, OP_NONE, 0, 1, 0, 1, 32'h100, 1, 0, "R5 irq re-taken after return");
    step(32'h102, OP_RI, 0, 0, 0, 1, 32'h21, 0, 0, "R4 second return");
    step(32'h22, OP_NONE, 0, 0, 0, 1, 32'h22, 0, 0, "R2 low irq ignored");
  endtask

  task automatic t_trace();
    do_reset();
    step(32'h40, OP_CW, 32'h8000_0000, 0, 0, 1, 32'h40, 0, 0, "R10 trace enable delay");
    step(32'h41, OP_NONE, 0, 0, 0, 1, 32'h2, 0, 1, "R6 trace taken");
    step(32'h3, OP_GT, 0, 0, 0, 1, 32'h3, 0, 0, "R7 handler not traced");
    chk32(rd_data, 32'h41, "R9 read trace return");
    step(32'h4, OP_RT, 0, 0, 0, 1, 32'h41, 0, 0, "R7 return from trace");
    step(32'h42, OP_NONE, 0, 0, 0, 1, 32'h2, 0, 1, "R7 next step traced");
    step(32'h3, OP_CW, 32'h0, 0, 0, 1, 32'h3, 0, 0, "R10 trace disable");
    step(32'h4, OP_RT, 0, 0, 0, 1, 32'h42, 0, 0, "R7 return after disable");
    step(32'h43, OP_NONE, 0, 0, 0, 1, 32'h43, 0, 0, "R10 trace stopped");
  endtask

  task automatic t_priority();
    do_reset();
    step(32'h10, OP_IV, 32'h100, 0, 0, 1, 32'h10, 0, 0, "R3 set vector");
    step(32'h11, OP_CW, 32'h8000_0001, 1, 0, 1, 32'h11, 0, 0, "R10 both enables");
    step(32'h12, OP_NONE, 0, 1, 0, 1, 32'h2, 0, 1, "R8 trace beats irq");
    step(32'h3, OP_NONE, 0, 1, 0, 1, 32'h3, 0, 0, "R8 irq held in trace handler");
    step(32'h4, OP_RT, 0, 1, 0, 1, 32'h100, 1, 0, "R8 irq on trace return");
    step(32'h101, OP_NONE, 0, 0, 0, 1, 32'h2, 0, 1, "R8 irq handler traced");
    step(32'h3, OP_GT, 0, 0, 0, 1, 32'h3, 0, 0, "R9 read in handler");
    chk32(rd_data, 32'h101, "R9 trace return is handler address");
    step(32'h4, OP_RT, 0, 0, 0, 1, 32'h101, 0, 0, "R7 back to irq handler");
    step(32'h102, OP_RI, 0, 0, 0, 1, 32'h2, 0, 1, "R4 traced irq return");
    step(32'h3, OP_GT, 0, 0, 0, 1, 32'h3, 0, 0, "R9 read saved target");
    chk32(rd_data, 32'h12, "R4 irq return held trace target");
  endtask

  task automatic t_reserved();
    do_reset();
    step(32'h10, OP_CW, 32'h7FFF_FFFE, 0, 0, 1, 32'h10, 0, 0, "R10 reserved write");
    step(32'h11, OP_NONE, 0, 1, 0, 1, 32'h11, 0, 0, "R10 reserved bits inert");
    step(32'h12, OP_NONE, 0, 1, 0, 1, 32'h12, 0, 0, "R10 reserved bits inert 2");
  endtask

  task automatic t_wait();
    do_reset();
    step(32'h10, OP_IV, 32'h100, 0, 0, 1, 32'h10, 0, 0, "R3 set vector");
    step(32'h11, OP_CW, 32'h1, 0, 0, 1, 32'h11, 0, 0, "R10 irq enable");
    step(32'h30, OP_IV, 32'h200, 1, 1, 1, 32'h30, 0, 0, "R11 wait blocks irq");
    step(32'h31, OP_NONE, 0, 1, 1, 1, 32'h31, 0, 0, "R11 wait holds");
    step(32'h32, OP_NONE, 0, 1, 0, 1, 32'h100, 1, 0, "R11 vector unchanged");
    step(32'h101, OP_RI, 0, 0, 1, 1, 32'h101, 0, 0, "R11 return held by wait");
    step(32'h101, OP_RI, 0, 0, 0, 1, 32'h32, 0, 0, "R11 return after wait");
  endtask

  task automatic t_idle();
    do_reset();
    step(32'h10, OP_IV, 32'h100, 0, 0, 1, 32'h10, 0, 0, "R3 set vector");
    step(32'h11, OP_CW, 32'h1, 0, 0, 1, 32'h11, 0, 0, "R10 irq enable");
    step(32'h50, OP_IV, 32'h300, 1, 0, 0, 32'h50, 0, 0, "R12 no retire no event");
    step(32'h51, OP_NONE, 0, 1, 0, 1, 32'h100, 1, 0, "R12 vector not written");
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_irq();
    t_trace();
    t_priority();
    t_reserved();
    t_wait();
    t_idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule